// File: doc/BRIEF.md
# Three-Lane 7:1 Parallel Serializer

This block turns a 21-bit parallel word, taken on every rising edge of a word clock, into three serial data lanes. Each lane sends seven bits per word period. A fourth output carries a framing clock that marks the word boundary. All serial logic runs from a bit clock at seven times the word clock rate, with its rising edges lined up with those of the word clock. The word-clock side reports each new word to the bit-clock side through a toggle flag. The serial side finds the word boundary from that flag, so no phase-detection logic is needed.

A word spends one full word period in a holding register before it is serialized. This gives the serial side a stable source for all seven slots. An active-low power-down input silences the link at once. While the link is silent, `drv_en_o` is low so that external pad drivers go to high impedance, and every serial output is held at 0. When power-down is released, the link comes back only after a programmable number of word boundaries, standing in for a clock-lock wait. It always restarts on a word boundary.

Top module: `tri_lane_serializer`

## Requirements
- R1: All 21 bits of `data_i` are captured at every rising edge of `word_clk` that is not in reset, and every captured word is later sent.
- R2: Lane k carries word bits 7k to 7k+6, least significant bit first, so word bit 7k is in slot 0 of lane k.
- R3: Each lane changes bit at every rising edge of `bit_clk`, giving seven bits per word. Slot 0 begins at the first `bit_clk` rising edge after each `word_clk` rising edge.
- R4: While enabled, `fwd_clk_o` is 1 in slots 0 to 3 and 0 in slots 4 to 6 of every word.
- R5: If `pdown_n` is 0 at a `bit_clk` rising edge, then from that edge `drv_en_o`, `fwd_clk_o` and every bit of `lane_o` are 0.
- R6: Once `pdown_n` is 1, `drv_en_o` rises together with slot 0 of the LOCK_WORDS-th word boundary seen with `pdown_n` high. Data is valid from that slot on.
- R7: Any low level on `pdown_n` restarts the lock count from zero, even one lasting a single bit period.
- R8: A word captured at `word_clk` edge n is sent in the seven slots that start one `bit_clk` period after `word_clk` edge n+1.
- R9: While `rst` is 1 (synchronous to both clocks), all outputs are 0, the lock count restarts, and the holding register clears. The first word sent after reset is therefore all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_clk | input | 1 | Word clock; rising edge captures `data_i` |
| bit_clk | input | 1 | Bit clock, 7x `word_clk`, rising edges aligned |
| rst | input | 1 | Synchronous active-high reset |
| pdown_n | input | 1 | Active-low power-down |
| data_i | input | 21 | Parallel input word |
| lane_o | output | 3 | Serial data lanes, bit k is lane k |
| fwd_clk_o | output | 1 | Framing clock, high 4 slots then low 3 |
| drv_en_o | output | 1 | Output driver enable; 0 means outputs are high impedance |

## Verification
The bench builds the block with three lanes, a ratio of seven, four high framing slots and a lock count of three words. With this short lock count, several complete release-and-relock cycles fit in one short run, including a one-bit power-down glitch in the middle of a count. A behavioural model tracks every bit-clock edge and compares all outputs at each edge, covering alternating, walking-one, all-ones and pseudo-random words.

// File: rtl/tls_pkg.sv
package tls_pkg;

    localparam int unsigned LANES_DEF    = 3;
    localparam int unsigned RATIO_DEF    = 7;
    localparam int unsigned FWD_HIGH_DEF = 4;

    typedef enum logic {
        LINK_QUIET = 1'b0,
        LINK_LIVE  = 1'b1
    } link_state_e;

    // Framing pattern: bit i is the level of the forwarded clock in slot i.
    function automatic logic [31:0] frame_pattern(input int unsigned ratio,
                                                  input int unsigned high);
        logic [31:0] p;
        p = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(high) && i < int'(ratio)) p[i] = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/tls_word_stage.sv
module tls_word_stage #(
    parameter int unsigned WORD_W = 21
) (
    input  logic              wclk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] held,
    output logic              tick
);
    logic [WORD_W-1:0] first;

    always_ff @(posedge wclk) begin
        if (rst) begin
            first <= '0;
            held  <= '0;
            tick  <= 1'b0;
        end else begin
            first <= din;
            held  <= first;
            tick  <= ~tick;
        end
    end
endmodule

// File: rtl/tls_slot_track.sv
module tls_slot_track
    import tls_pkg::*;
#(
    parameter int unsigned RATIO    = RATIO_DEF,
    parameter int unsigned FWD_HIGH = FWD_HIGH_DEF
) (
    input  logic                       bclk,
    input  logic                       rst,
    input  logic                       tick,
    output logic                       bnd,
    output logic [$clog2(RATIO)-1:0]   slot,
    output logic                       fwd_bit
);
    localparam int unsigned SW = $clog2(RATIO);
    localparam logic [31:0] PAT_FULL = frame_pattern(RATIO, FWD_HIGH);
    localparam logic [RATIO-1:0] PAT = PAT_FULL[RATIO-1:0];

    logic             tick_q;
    logic             seen;
    logic [RATIO-1:0] fwd_sr;

    assign bnd     = tick ^ tick_q;
    assign fwd_bit = fwd_sr[0];

    always_ff @(posedge bclk) begin
        if (rst) begin
            tick_q <= 1'b0;
            slot   <= '0;
            seen   <= 1'b0;
            fwd_sr <= '0;
        end else begin
            tick_q <= tick;
            if (bnd) begin
                slot   <= '0;
                seen   <= 1'b1;
                fwd_sr <= PAT;
            end else begin
                if (slot != SW'(RATIO-1)) slot <= slot + 1'b1;
                fwd_sr <= fwd_sr >> 1;
            end
        end
    end

    // Word boundaries arrive exactly every RATIO bit clocks.
    assert_word_period_R3: assert property (@(posedge bclk) disable iff (rst)
        (bnd && seen) |-> (slot == SW'(RATIO-1)));

endmodule

// File: rtl/tls_lane_shift.sv
module tls_lane_shift #(
    parameter int unsigned RATIO = 7
) (
    input  logic             bclk,
    input  logic             rst,
    input  logic             load,
    input  logic [RATIO-1:0] word,
    output logic             bit_o
);
    logic [RATIO-1:0] sr;

    always_ff @(posedge bclk) begin
        if (rst)       sr <= '0;
        else if (load) sr <= word;
        else           sr <= sr >> 1;
    end

    assign bit_o = sr[0];
endmodule

// File: rtl/tls_lock_gate.sv
module tls_lock_gate
    import tls_pkg::*;
#(
    parameter int unsigned LOCK_WORDS = 750000
) (
    input  logic bclk,
    input  logic rst,
    input  logic pdown_n,
    input  logic bnd,
    output logic live
);
    localparam int unsigned CW = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;

    link_state_e    st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge bclk) begin
        if (rst || !pdown_n) begin
            st  <= LINK_QUIET;
            cnt <= '0;
        end else if (st == LINK_QUIET && bnd) begin
            if (cnt == CW'(LOCK_WORDS-1)) st  <= LINK_LIVE;
            else                          cnt <= cnt + 1'b1;
        end
    end

    assign live = (st == LINK_LIVE);

    assert_lock_count_R6: assert property (@(posedge bclk) disable iff (rst)
        $rose(live) |-> ($past(cnt) == CW'(LOCK_WORDS-1)));

    assert_restart_R7: assert property (@(posedge bclk) disable iff (rst)
        !pdown_n |=> (cnt == '0 && !live));

endmodule

// File: rtl/tri_lane_serializer.sv
module tri_lane_serializer
    import tls_pkg::*;
#(
    parameter int unsigned LANES      = LANES_DEF,
    parameter int unsigned RATIO      = RATIO_DEF,
    parameter int unsigned FWD_HIGH   = FWD_HIGH_DEF,
    parameter int unsigned LOCK_WORDS = 750000
) (
    input  logic                   word_clk,
    input  logic                   bit_clk,
    input  logic                   rst,
    input  logic                   pdown_n,
    input  logic [LANES*RATIO-1:0] data_i,
    output logic [LANES-1:0]       lane_o,
    output logic                   fwd_clk_o,
    output logic                   drv_en_o
);
    localparam int unsigned WORD_W = LANES * RATIO;
    localparam int unsigned SW     = $clog2(RATIO);

    logic [WORD_W-1:0] held;
    logic              tick;
    logic              bnd;
    logic [SW-1:0]     slot;
    logic              fwd_bit;
    logic              live;
    logic [LANES-1:0]  lane_raw;

    tls_word_stage #(.WORD_W(WORD_W)) u_word (
        .wclk(word_clk), .rst(rst), .din(data_i), .held(held), .tick(tick)
    );

    tls_slot_track #(.RATIO(RATIO), .FWD_HIGH(FWD_HIGH)) u_slot (
        .bclk(bit_clk), .rst(rst), .tick(tick),
        .bnd(bnd), .slot(slot), .fwd_bit(fwd_bit)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tls_lane_shift #(.RATIO(RATIO)) u_lane (
            .bclk (bit_clk),
            .rst  (rst),
            .load (bnd),
            .word (held[k*RATIO +: RATIO]),
            .bit_o(lane_raw[k])
        );
    end

    tls_lock_gate #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
        .bclk(bit_clk), .rst(rst), .pdown_n(pdown_n), .bnd(bnd), .live(live)
    );

    assign drv_en_o  = live;
    assign lane_o    = live ? lane_raw : '0;
    assign fwd_clk_o = live & fwd_bit;

    assert_fwd_high_R4: assert property (@(posedge bit_clk) disable iff (rst)
        (drv_en_o && slot < SW'(FWD_HIGH)) |-> fwd_clk_o);

    assert_fwd_low_R4: assert property (@(posedge bit_clk) disable iff (rst)
        (drv_en_o && slot >= SW'(FWD_HIGH)) |-> !fwd_clk_o);

    assert_pd_silence_R5: assert property (@(posedge bit_clk) disable iff (rst)
        !pdown_n |=> (!drv_en_o && lane_o == '0 && !fwd_clk_o));

    assert_start_slot0_R6: assert property (@(posedge bit_clk) disable iff (rst)
        $rose(drv_en_o) |-> (slot == '0));

endmodule

// File: tb/tb_tri_lane_serializer.sv
module tb_tri_lane_serializer;
    localparam int BIT_PERIOD = 10;
    localparam int LANES = 3;
    localparam int RATIO = 7;
    localparam int FWD_HIGH = 4;
    localparam int LOCK = 3;
    localparam int W = LANES * RATIO;

    logic word_clk = 1'b0;
    logic bit_clk  = 1'b0;
    logic rst      = 1'b1;
    logic pdown_n  = 1'b1;
    logic [W-1:0] data_i = '0;
    logic [LANES-1:0] lane_o;
    logic fwd_clk_o;
    logic drv_en_o;

    tri_lane_serializer #(.LANES(LANES), .RATIO(RATIO), .FWD_HIGH(FWD_HIGH),
                          .LOCK_WORDS(LOCK)) dut (
        .word_clk(word_clk), .bit_clk(bit_clk), .rst(rst), .pdown_n(pdown_n),
        .data_i(data_i), .lane_o(lane_o), .fwd_clk_o(fwd_clk_o), .drv_en_o(drv_en_o)
    );

    // Aligned clocks: word clock high for 4 bit periods, low for 3.
    initial begin
        forever begin
            for (int p = 0; p < RATIO; p++) begin
                #(BIT_PERIOD/2);
                bit_clk = 1'b1;
                if (p == 0) word_clk = 1'b1;
                if (p == 4) word_clk = 1'b0;
                #(BIT_PERIOD/2);
                bit_clk = 1'b0;
            end
        end
    end

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // Reference model state
    int e = 0;
    logic [W-1:0] q[$];
    bit tog_prev = 0;
    logic [W-1:0] ref_word = '0;
    int ref_slot = RATIO;
    int ref_cnt = 0;
    bit ref_live = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s edge %0d: actual=%0h expected=%0h", req, e, act, exp);
        end
    endtask

    // Processes the bit_clk rising edge just passed, then compares outputs.
    task automatic step();
        bit pulse;
        logic [LANES-1:0] exp_lane;
        bit exp_fwd;
        @(negedge bit_clk);
        pulse = tog_prev && !rst;
        if (e % RATIO == 0) begin
            if (rst) q.delete();
            else q.push_back(data_i);
            tog_prev = !rst;
        end else begin
            tog_prev = 0;
        end
        if (rst) begin
            ref_word = '0; ref_slot = RATIO;
        end else if (pulse) begin
            ref_word = (q.size() >= 2) ? q[q.size()-2] : '0;
            ref_slot = 0;
        end else if (ref_slot < RATIO) begin
            ref_slot++;
        end
        if (rst || !pdown_n) begin
            ref_cnt = 0; ref_live = 0;
        end else if (!ref_live && pulse) begin
            if (ref_cnt == LOCK-1) ref_live = 1;
            else ref_cnt++;
        end
        for (int k = 0; k < LANES; k++)
            exp_lane[k] = ref_live && ref_slot < RATIO && ref_word[k*RATIO + ref_slot];
        exp_fwd = ref_live && ref_slot < FWD_HIGH;
        chk(lane_o == exp_lane, "R1 R2 R3 R8 lanes", int'(lane_o), int'(exp_lane));
        chk(fwd_clk_o == exp_fwd, "R4 fwd clock", int'(fwd_clk_o), int'(exp_fwd));
        chk(drv_en_o == ref_live, "R5 R6 R7 R9 enable", int'(drv_en_o), int'(ref_live));
        e++;
    endtask

    function automatic logic [W-1:0] pat(input int w);
        case (w % 5)
            0: return '1;
            1: return '0;
            2: return (w % 2) ? 21'h155555 : 21'h0AAAAA;
            3: return 21'(1) << (w % W);
            default: return 21'($urandom());
        endcase
    endfunction

    task automatic run_words(input int n, input int base);
        for (int w = 0; w < n; w++) begin
            data_i = pat(base + w);
            repeat (RATIO) step();
        end
    endtask

    initial begin
        // R9: reset state
        repeat (20) step();
        rst = 1'b0;
        run_words(30, 0);
        // R5: power-down mid stream, then R6 relock
        repeat (3) step();
        pdown_n = 1'b0;
        run_words(5, 40);
        pdown_n = 1'b1;
        run_words(10, 50);
        // R7: single-bit glitch during a lock count
        pdown_n = 1'b0;
        step();
        pdown_n = 1'b1;
        run_words(2, 60);
        repeat (2) step();
        pdown_n = 1'b0;
        step();
        pdown_n = 1'b1;
        run_words(12, 70);
        // R9: reset during live traffic, then recovery
        rst = 1'b1;
        run_words(2, 90);
        rst = 1'b0;
        run_words(10, 95);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(BIT_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule